// File: doc/BRIEF.md
# RTC Register Target on I2C

This block lets an I2C bus master reach the registers of a real-time clock. It runs entirely on the system clock. The bus lines enter through two-flop synchronisers, and SDA is driven through an open-drain enable. The block detects START and STOP conditions and answers one fixed device address. It keeps a byte-wide register pointer that walks through a small register file. The time counters themselves sit outside the block.

The seven time registers occupy consecutive addresses: seconds, minutes, hours, days, weekdays, months and years. When the device address is matched, the seven time values are copied from a parallel input into a shadow. Every read in that access is served from the shadow, so a byte sequence never shows a counter roll-over part way through. Bytes written to the time registers also land in the shadow. At the closing STOP, the whole shadow is handed to the counters with a single one-cycle commit strobe. The other addresses are plain byte storage held inside the block.

Top module: `rtc_i2c_target`

## Requirements
- R1: After reset SDA is released and no commit strobe is issued. A falling SDA while SCL is high is a START, and a rising SDA while SCL is high is a STOP. After a STOP, clock pulses without a new START get no response.
- R2: Only the address bytes A2h (write) and A3h (read) are acknowledged. Any other address byte is not acknowledged, and the rest of that transfer is ignored: it changes neither the pointer nor any register.
- R3: In a write transfer, the first data byte after the address loads the register pointer.
- R4: The pointer advances by one for each data byte written or sent. It wraps from 0Ah, the highest implemented address, back to 00h.
- R5: A read started by a repeated START, or by a STOP followed by a START, returns the byte at the current pointer first.
- R6: Addresses 04h to 0Ah hold seconds, minutes, hours, days, weekdays, months and years, in that order. On the 56-bit time buses, seconds sit in bits 7:0 and each following register takes the next byte up, so years sit in bits 55:48.
- R7: After each received byte that is accepted, the target holds SDA low for the whole high period of the ninth clock.
- R8: When the master does not acknowledge a read byte, the target releases SDA and sends no more data until the next START.
- R9: The time values read within one access come from a snapshot taken when the address is matched. Changes on the time input after that point do not appear in the access.
- R10: Written time bytes are sent out only at the STOP, as exactly one one-cycle commit strobe. The time output then holds the written bytes, and the unwritten time fields keep their snapshot values.
- R11: The target changes SDA only after a falling SCL edge, never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| sda_oe | output | 1 | 1 pulls the data line low |
| time_in | input | 56 | Current counter values, seconds in bits 7:0 |
| time_out | output | 56 | Shadow contents to load into the counters |
| time_wr | output | 1 | One-cycle commit strobe for time_out |

## Verification
The bench builds the block with its default parameters: device address 51h and eleven registers, with the time group based at 04h. This configuration is small enough to sweep every one of the 256 possible address bytes. It also allows a read burst starting at each of the eleven pointer values, and every burst is long enough to cross the wrap from 0Ah back to 00h. The snapshot and commit rules are checked by changing the time input in the middle of a read access and in the middle of a write access.

// File: rtl/rtc_i2c_target.sv
module rtc_i2c_target #(
  parameter logic [6:0] DEV_ADDR = 7'h51,
  parameter int NREG = 11,
  parameter int TBASE = 4,
  parameter int NT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            sda_oe,
  input  logic [8*NT-1:0] time_in,
  output logic [8*NT-1:0] time_out,
  output logic            time_wr
);
  localparam int AW = $clog2(NREG);
  localparam logic [7:0] LAST = 8'(NREG - 1);
  localparam logic [7:0] TLO = 8'(TBASE);
  localparam logic [7:0] THI = 8'(TBASE + NT);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_WR, S_RD} st_t;

  logic [1:0] scl_y, sda_y;
  logic scl_q, sda_q;
  wire scl_s = scl_y[1];
  wire sda_s = sda_y[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_y <= 2'b11; sda_y <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_y <= {scl_y[0], scl_in}; sda_y <= {sda_y[0], sda_in};
      scl_q <= scl_s; sda_q <= sda_s;
    end

  wire start = scl_s & scl_q & sda_q & ~sda_s;
  wire stop  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise  = scl_s & ~scl_q;
  wire fall  = ~scl_s & scl_q;

  st_t st;
  logic [7:0] sr, tx, ptr;
  logic [3:0] bcnt;
  logic rw, first, dirty;
  logic [7:0] mem [NREG];
  logic [7:0] sh [NT];
  logic [7:0] rd_b;

  wire in_time = (ptr >= TLO) && (ptr < THI);
  wire [7:0] nxt = (ptr >= LAST) ? 8'd0 : ptr + 8'd1;

  always_comb begin
    rd_b = 8'h00;
    if (in_time) rd_b = sh[3'(ptr - TLO)];
    else if (ptr <= LAST) rd_b = mem[AW'(ptr)];
  end

  for (genvar g = 0; g < NT; g++) begin : g_out
    assign time_out[8*g +: 8] = sh[g];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; sr <= '0; tx <= '0; ptr <= '0; bcnt <= '0;
      rw <= 1'b0; first <= 1'b0; dirty <= 1'b0; sda_oe <= 1'b0; time_wr <= 1'b0;
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
      for (int i = 0; i < NT; i++) sh[i] <= '0;
    end else begin
      time_wr <= 1'b0;
      if (start) begin
        st <= S_ADDR; bcnt <= '0; sda_oe <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE; sda_oe <= 1'b0;
        if (dirty) begin time_wr <= 1'b1; dirty <= 1'b0; end
      end else if (st != S_IDLE) begin
        if (rise) begin
          if (bcnt < 4'd8) begin
            sr <= {sr[6:0], sda_s}; bcnt <= bcnt + 4'd1;
          end else begin
            bcnt <= 4'd9;
            if (st == S_RD && sda_s) st <= S_IDLE;
          end
        end else if (fall) begin
          if (bcnt == 4'd8) begin
            case (st)
              S_ADDR:
                if (sr[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1; rw <= sr[0]; first <= ~sr[0];
                  if (!dirty)
                    for (int i = 0; i < NT; i++) sh[i] <= time_in[8*i +: 8];
                end else st <= S_IDLE;
              S_WR: begin
                sda_oe <= 1'b1;
                if (first) begin
                  ptr <= sr; first <= 1'b0;
                end else begin
                  if (in_time) begin sh[3'(ptr - TLO)] <= sr; dirty <= 1'b1; end
                  else if (ptr <= LAST) mem[AW'(ptr)] <= sr;
                  ptr <= nxt;
                end
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (bcnt == 4'd9) begin
            bcnt <= '0; sda_oe <= 1'b0;
            if (st == S_RD || (st == S_ADDR && rw)) begin
              st <= S_RD; tx <= rd_b; sda_oe <= ~rd_b[7]; ptr <= nxt;
            end else if (st == S_ADDR) st <= S_WR;
          end else if (st == S_RD && bcnt != 4'd0) begin
            sda_oe <= ~tx[3'(7 - bcnt)];
          end
        end
      end
    end

  assert_sda_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(fall || start || stop));
  assert_commit_at_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |-> $past(stop));
  assert_commit_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |=> !time_wr);
  assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);
  assert_no_foreign_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && fall && bcnt == 4'd8 && sr[7:1] != DEV_ADDR) |=> !sda_oe);
  assert_ack_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && bcnt == 4'd9 && !fall && !start && !stop) |-> sda_oe);
endmodule

// File: tb/tb_rtc_i2c_target.sv
module tb_rtc_i2c_target;
  localparam int CLK_P = 10;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic [55:0] time_in = '0;
  logic [55:0] time_out;
  logic sda_oe, time_wr;
  wire sda = ~(m_low | sda_oe);

  int checks = 0, errors = 0, wr_cnt = 0, viol = 0;
  logic [55:0] last_out = '0;
  logic [7:0] val [11];

  always #(CLK_P/2) clk = ~clk;

  rtc_i2c_target dut (.clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .sda_oe(sda_oe), .time_in(time_in), .time_out(time_out), .time_wr(time_wr));

  always @(posedge clk) if (time_wr) begin wr_cnt++; last_out <= time_out; end

  logic scl_p = 1'b1, oe_p = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && scl_p && sda_oe != oe_p) viol++;
    scl_p <= scl; oe_p <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic bit_io(input logic b, output logic r);
    @(negedge clk) m_low = ~b;
    repeat (H) @(negedge clk);
    scl = 1'b1;
    repeat (H/2) @(negedge clk);
    r = sda;
    repeat (H/2) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic do_start;
    if (!scl) begin
      @(negedge clk) m_low = 1'b0;
      repeat (H) @(negedge clk);
      scl = 1'b1;
      repeat (H) @(negedge clk);
    end
    m_low = 1'b1;
    repeat (H) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic do_stop;
    @(negedge clk) m_low = 1'b1;
    repeat (H) @(negedge clk);
    scl = 1'b1;
    repeat (H) @(negedge clk);
    m_low = 1'b0;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask

  task automatic rbyte(input logic ack_m, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); b[i] = r; end
    bit_io(~ack_m, r);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    do_start; wbyte(8'hA2, a); wbyte(p, a); do_stop;
  endtask

  function automatic logic [55:0] pack_time();
    logic [55:0] t;
    for (int i = 0; i < 7; i++) t[8*i +: 8] = val[4+i];
    return t;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a, exp_a;
    logic [7:0] d;
    int c0;
    for (int i = 0; i < 11; i++) val[i] = 8'(8'h11 + i*23);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0 && time_wr == 1'b0, "R1 reset", {sda_oe, time_wr}, 0);

    // R3 R7: pointer 00h then fill all eleven registers, every byte acknowledged
    do_start; wbyte(8'hA2, a); chk(a, "R7 addr ack", a, 1);
    wbyte(8'h00, a); chk(a, "R7 ptr ack", a, 1);
    for (int i = 0; i < 11; i++) begin wbyte(val[i], a); chk(a, "R7 data ack", a, 1); end
    chk(wr_cnt == 0, "R10 no commit before stop", wr_cnt, 0);
    do_stop;
    chk(wr_cnt == 1, "R10 single commit", wr_cnt, 1);
    chk(last_out == pack_time(), "R6 time packing", last_out, pack_time());
    time_in = pack_time();

    // R1: clocking after STOP without START is ignored
    wbyte(8'hA2, a); chk(!a, "R1 no start no ack", a, 0);
    do_stop;

    // R4 R5: reads from every pointer, crossing the wrap
    for (int p = 0; p < 11; p++) begin
      do_start; wbyte(8'hA2, a); wbyte(8'(p), a);
      if (p % 2 == 1) do_stop;
      do_start; wbyte(8'hA3, a); chk(a, "R2 read addr ack", a, 1);
      for (int i = 0; i < 13; i++) begin
        rbyte(i != 12, d);
        chk(d == val[(p+i) % 11], "R4 R5 burst", d, val[(p+i) % 11]);
      end
      do_stop;
    end

    // R9: snapshot stays coherent within one read access
    set_ptr(8'h04);
    do_start; wbyte(8'hA3, a);
    rbyte(1'b1, d); chk(d == val[4], "R9 first", d, val[4]);
    time_in = ~pack_time();
    for (int i = 1; i < 7; i++) begin
      rbyte(i != 6, d); chk(d == val[4+i], "R9 snapshot", d, val[4+i]);
    end
    do_stop;
    set_ptr(8'h04);
    do_start; wbyte(8'hA3, a); rbyte(1'b0, d); do_stop;
    chk(d == ~val[4], "R9 new access", d, ~val[4]);
    time_in = pack_time();

    // R8: master NACK stops the data
    set_ptr(8'h00);
    do_start; wbyte(8'hA3, a);
    rbyte(1'b0, d); chk(d == val[0], "R8 byte", d, val[0]);
    rbyte(1'b0, d); chk(d == 8'hFF, "R8 silent after nack", d, 8'hFF);
    do_stop;
    do_start; wbyte(8'hA3, a); rbyte(1'b0, d); do_stop;
    chk(d == val[1], "R8 R4 one advance", d, val[1]);

    // R2: foreign address transfer changes nothing
    set_ptr(8'h02);
    do_start; wbyte(8'hA4, a); chk(!a, "R2 foreign nack", a, 0);
    wbyte(8'h00, a); chk(!a, "R2 ignored byte", a, 0);
    wbyte(8'h55, a); chk(!a, "R2 ignored byte", a, 0);
    do_stop;
    do_start; wbyte(8'hA3, a); rbyte(1'b0, d); do_stop;
    chk(d == val[2], "R2 pointer kept", d, val[2]);
    set_ptr(8'h00);
    do_start; wbyte(8'hA3, a); rbyte(1'b0, d); do_stop;
    chk(d == val[0], "R2 reg kept", d, val[0]);

    // R10: partial time write, commit at STOP only
    c0 = wr_cnt;
    do_start; wbyte(8'hA2, a); wbyte(8'h05, a); wbyte(8'h33, a); wbyte(8'h12, a);
    time_in = 56'hFFEEDDCCBBAA99;
    repeat (20) @(negedge clk);
    chk(wr_cnt == c0, "R10 held until stop", wr_cnt, c0);
    do_stop;
    val[5] = 8'h33; val[6] = 8'h12;
    chk(wr_cnt == c0 + 1, "R10 one strobe", wr_cnt, c0 + 1);
    chk(last_out == pack_time(), "R10 R6 merged shadow", last_out, pack_time());
    time_in = pack_time();

    // R2: sweep all address bytes
    for (int b = 0; b < 256; b++) begin
      do_start; wbyte(8'(b), a);
      exp_a = (b == 8'hA2) || (b == 8'hA3);
      chk(a == exp_a, "R2 address sweep", {b[7:0], a}, {b[7:0], exp_a});
      if (a && b[0]) rbyte(1'b0, d);
      do_stop;
    end

    chk(viol == 0, "R11 R7 sda stable while scl high", viol, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule